// File: doc/BRIEF.md
# Three-Channel Prescaled Interval Timer

This peripheral holds three independent 16-bit up-counters that share one input clock. Each counter can advance on every input clock or on a prescaled tick, and it runs either freely across the full 16-bit range or as an interval timer that returns to zero after a programmed terminal value. Each counter compares its value against three programmable match words and raises its own interrupt line when one of its enabled status bits is set.

Software reaches the block over a single-cycle register bus. A write takes effect on the clock edge where `we_i` is high. Reads are combinational from `addr_i`. Registers are grouped by function, and the three channels of one group occupy consecutive words. An interrupt handler reads the status word and writes the same value back to acknowledge the events it has seen.

Top module: `tri_tick_timer`

## Requirements
- R1: Register groups sit at byte offsets 0x00 (clock control), 0x0C (counter control), 0x18 (count, read-only), 0x24 (interval), 0x30/0x3C/0x48 (match 1..3), 0x54 (status) and 0x60 (enable). Channel n sits at the group offset plus 4*n. Any other address reads 0, and writes to it have no effect.
- R2: In clock control, bit 0 enables the prescaler and bits [4:1] hold N. With bit 0 set, the count advances once every 2^(N+1) input clocks after a restart, so 0x9 divides by 32. With bit 0 clear, the count advances on every clock.
- R3: Counter-control bit 0 set holds the count. Clearing it resumes counting from the held value.
- R4: Writing counter control with bit 4 set forces the count and the prescaler phase to zero on that edge, even while the counter is stopped. Bit 4 always reads back 0, and the register reads back bits [1:0] only.
- R5: With counter-control bit 1 clear, the count wraps from 0xFFFF to 0 and sets status bit 4.
- R6: With counter-control bit 1 set, the count goes to 0 on the tick after it equals the interval register, and status bit 0 is set on that same edge.
- R7: Status bit k (k = 1..3) is set on any tick that advances the count to a value equal to match register k. A restart does not set it.
- R8: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. If a bit is set and cleared in the same cycle, the set wins.
- R9: Each channel drives its own `irq_o` bit, the OR over its status bits ANDed with its enable bits. Channels do not affect one another.
- R10: After reset every register reads 0, except counter control, which reads 0x1 (stopped). All interrupts are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Byte address of the register accessed |
| we_i | input | 1 | Write strobe, sampled on the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 3 | Per-channel interrupt, one bit per channel |

## Verification
A corrupted prescaler phase or counter state shows up on the count read within one tick. Because the bench samples the count at exact cycle offsets after a restart, an off-by-one in the prescaler limit or in the interval compare is caught the first time the count is read. A wrong status update (a lost set, a clear that beats a set, a spurious match on restart) appears on the status read and on `irq_o` in the cycle after the edge concerned. The overflow path becomes visible only after 65536 ticks, so the bench runs a full free-running wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    GRP_CLK = 4'd0,
    GRP_CNT = 4'd1,
    GRP_VAL = 4'd2,
    GRP_IVL = 4'd3,
    GRP_M1  = 4'd4,
    GRP_M2  = 4'd5,
    GRP_M3  = 4'd6,
    GRP_ISR = 4'd7,
    GRP_IER = 4'd8
  } grp_e;

  localparam int NUM_GRP   = 9;
  localparam int NUM_MATCH = 3;
  // event vector: [0] interval wrap, [NUM_MATCH:1] matches, [NUM_MATCH+1] overflow
  localparam int NUM_EV    = NUM_MATCH + 2;
  localparam int EV_IVL    = 0;
  localparam int EV_OVF    = NUM_MATCH + 1;

  localparam int CC_STOP = 0;
  localparam int CC_IVL  = 1;
  localparam int CC_RST  = 4;
  localparam int CK_PS   = 0;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic             ps_en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  localparam int PRE_W = 2 ** DIV_W;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   lim_w;
  logic [PRE_W-1:0] limit;
  logic [DIV_W:0]   shamt;

  assign shamt  = {1'b0, div_i} + 1'b1;
  assign lim_w  = ((PRE_W + 1)'(1) << shamt) - 1'b1;
  assign limit  = lim_w[PRE_W-1:0];
  assign tick_o = !ps_en_i || (pre_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (restart_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end

  // a prescaled tick is never followed directly by another
  assert_tick_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ps_en_i && tick_o && run_i) |=> (!ps_en_i || !tick_o));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            step_i,
  input  logic                            restart_i,
  input  logic                            ivl_mode_i,
  input  logic [CNT_W-1:0]                interval_i,
  input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_i,
  output logic [CNT_W-1:0]                count_o,
  output logic [NUM_EV-1:0]               ev_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             adv;
  logic             wrap_hit;
  logic             at_top;

  assign adv      = step_i && !restart_i;
  assign wrap_hit = ivl_mode_i && (cnt_q == interval_i);
  assign at_top   = (cnt_q == {CNT_W{1'b1}});
  assign nxt      = wrap_hit ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= nxt;
    end
  end

  assign ev_o[EV_IVL] = adv && wrap_hit;
  assign ev_o[EV_OVF] = adv && !ivl_mode_i && at_top;

  for (genvar k = 0; k < NUM_MATCH; k++) begin : g_match
    assign ev_o[k+1] = adv && (nxt == match_i[k]);
  end

  assign count_o = cnt_q;

  assert_restart_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (count_o == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !restart_i) |=> $stable(count_o));

  assert_ivl_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o[EV_IVL] |=> (count_o == '0));

  assert_ovf_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_o[EV_OVF] |=> (count_o == '0));

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [3:0]        wgrp_i,
  input  logic [CNT_W-1:0]  wdata_i,
  input  logic [3:0]        rgrp_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);

  localparam int CK_W = DIV_W + 1;

  logic [CK_W-1:0]                 ck_ctrl_q;
  logic                            stop_q;
  logic                            ivl_mode_q;
  logic [CNT_W-1:0]                interval_q;
  logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
  logic [NUM_EV-1:0]               isr_q;
  logic [NUM_EV-1:0]               ier_q;

  logic             restart;
  logic             tick;
  logic [CNT_W-1:0] count;
  logic [NUM_EV-1:0] ev;

  assign restart = wr_i && (wgrp_i == GRP_CNT) && wdata_i[CC_RST];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_ctrl_q  <= '0;
      stop_q     <= 1'b1;
      ivl_mode_q <= 1'b0;
      interval_q <= '0;
      match_q    <= '0;
      ier_q      <= '0;
    end else if (wr_i) begin
      case (grp_e'(wgrp_i))
        GRP_CLK: ck_ctrl_q <= wdata_i[CK_W-1:0];
        GRP_CNT: begin
          stop_q     <= wdata_i[CC_STOP];
          ivl_mode_q <= wdata_i[CC_IVL];
        end
        GRP_IVL: interval_q <= wdata_i;
        GRP_M1:  match_q[0] <= wdata_i;
        GRP_M2:  match_q[1] <= wdata_i;
        GRP_M3:  match_q[2] <= wdata_i;
        GRP_IER: ier_q      <= wdata_i[NUM_EV-1:0];
        default: ;
      endcase
    end
  end

  // write-one-to-clear; a new event in the same cycle wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_q <= '0;
    end else if (wr_i && (wgrp_i == GRP_ISR)) begin
      isr_q <= (isr_q & ~wdata_i[NUM_EV-1:0]) | ev;
    end else begin
      isr_q <= isr_q | ev;
    end
  end

  tmr_prescaler #(
    .DIV_W (DIV_W)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (!stop_q),
    .restart_i (restart),
    .ps_en_i   (ck_ctrl_q[CK_PS]),
    .div_i     (ck_ctrl_q[CK_W-1:1]),
    .tick_o    (tick)
  );

  tmr_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (tick && !stop_q),
    .restart_i  (restart),
    .ivl_mode_i (ivl_mode_q),
    .interval_i (interval_q),
    .match_i    (match_q),
    .count_o    (count),
    .ev_o       (ev)
  );

  always_comb begin
    rdata_o = '0;
    case (grp_e'(rgrp_i))
      GRP_CLK: rdata_o = DATA_W'(ck_ctrl_q);
      GRP_CNT: rdata_o = DATA_W'({ivl_mode_q, stop_q});
      GRP_VAL: rdata_o = DATA_W'(count);
      GRP_IVL: rdata_o = DATA_W'(interval_q);
      GRP_M1:  rdata_o = DATA_W'(match_q[0]);
      GRP_M2:  rdata_o = DATA_W'(match_q[1]);
      GRP_M3:  rdata_o = DATA_W'(match_q[2]);
      GRP_ISR: rdata_o = DATA_W'(isr_q);
      GRP_IER: rdata_o = DATA_W'(ier_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = |(isr_q & ier_q);

  assert_isr_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev != '0) |=> ((isr_q & $past(ev)) == $past(ev)));

  assert_isr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && (wgrp_i == GRP_ISR) && (ev == '0))
      |=> ((isr_q & $past(wdata_i[NUM_EV-1:0])) == '0));

endmodule

// File: rtl/tri_tick_timer.sv
module tri_tick_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);

  localparam int STRIDE = 4 * NUM_CH;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            hit;
  logic [3:0]      sel_grp;
  logic [CH_W-1:0] sel_ch;
  logic [NUM_CH-1:0] wr_ch;
  logic [DATA_W-1:0] ch_rdata [NUM_CH];
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

  // groups interleave channels at a 4-byte stride
  always_comb begin
    hit     = 1'b0;
    sel_grp = '0;
    sel_ch  = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (addr_i == ADDR_W'(g * STRIDE + c * 4)) begin
          hit     = 1'b1;
          sel_grp = 4'(g);
          sel_ch  = CH_W'(c);
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_ch[c] = we_i && hit && (sel_ch == CH_W'(c));

    tmr_channel #(
      .CNT_W  (CNT_W),
      .DIV_W  (DIV_W),
      .DATA_W (DATA_W)
    ) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_ch[c]),
      .wgrp_i  (sel_grp),
      .wdata_i (wdata_i[CNT_W-1:0]),
      .rgrp_i  (sel_grp),
      .rdata_o (ch_rdata[c]),
      .irq_o   (irq_o[c])
    );
  end

  assign rdata_o = hit ? ch_rdata[sel_ch] : '0;

endmodule

// File: tb/tri_tick_timer_tb.sv
`timescale 1ns/1ps
module tri_tick_timer_tb;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [7:0]  addr_i;
  logic        we_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [2:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  tri_tick_timer u_dut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o)
  );

  typedef struct packed {
    logic        we;
    logic        chk;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [2:0]  irq;
    logic [3:0]  req;
  } vec_t;

  // one row per clock; reads are sampled before the edge of their row
  localparam vec_t VEC [41] = '{
    '{1'b0, 1'b1, 8'h0C, 32'h00, 32'h01, 3'b000, 4'd10}, // R10 ctrl reset
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd10}, // R10 count reset
    '{1'b1, 1'b0, 8'h0C, 32'h10, 32'h00, 3'b000, 4'd4},  // R4 restart + run
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd4},  // R4
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h01, 3'b000, 4'd2},  // R2 no prescale
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h02, 3'b000, 4'd2},  // R2
    '{1'b1, 1'b0, 8'h0C, 32'h01, 32'h00, 3'b000, 4'd3},  // R3 stop
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h04, 3'b000, 4'd3},  // R3
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h04, 3'b000, 4'd3},  // R3 held
    '{1'b0, 1'b1, 8'h0C, 32'h00, 32'h01, 3'b000, 4'd4},  // R4 readback
    '{1'b1, 1'b0, 8'h0C, 32'h00, 32'h00, 3'b000, 4'd3},  // R3 resume
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h04, 3'b000, 4'd3},  // R3
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h05, 3'b000, 4'd3},  // R3 from held
    '{1'b1, 1'b0, 8'h00, 32'h03, 32'h00, 3'b000, 4'd2},  // R2 divide by 4
    '{1'b1, 1'b0, 8'h0C, 32'h10, 32'h00, 3'b000, 4'd4},  // R4 restart
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h00, 3'b000, 4'd2},  // R2
    '{1'b0, 1'b1, 8'h18, 32'h00, 32'h01, 3'b000, 4'd2},  // R2 first tick
    '{1'b0, 1'b1, 8'h00, 32'h00, 32'h03, 3'b000, 4'd2},  // R2 readback
    '{1'b1, 1'b0, 8'h28, 32'h03, 32'h00, 3'b000, 4'd6},  // R6 interval ch1
    '{1'b1, 1'b0, 8'h34, 32'h02, 32'h00, 3'b000, 4'd7},  // R7 match1 ch1
    '{1'b1, 1'b0, 8'h64, 32'h01, 32'h00, 3'b000, 4'd9},  // R9 enable ch1
    '{1'b1, 1'b0, 8'h10, 32'h12, 32'h00, 3'b000, 4'd6},  // R6 run interval
    '{1'b0, 1'b1, 8'h1C, 32'h00, 32'h00, 3'b000, 4'd6},  // R6
    '{1'b0, 1'b1, 8'h1C, 32'h00, 32'h01, 3'b000, 4'd6},  // R6
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h02, 3'b000, 4'd7},  // R7 match seen
    '{1'b0, 1'b1, 8'h1C, 32'h00, 32'h03, 3'b000, 4'd6},  // R6 at interval
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h0F, 3'b010, 4'd6},  // R6 wrap + R7 zero matches
    '{1'b0, 1'b1, 8'h1C, 32'h00, 32'h01, 3'b010, 4'd6},  // R6 restarted at 0
    '{1'b1, 1'b0, 8'h58, 32'h01, 32'h00, 3'b010, 4'd8},  // R8 clear bit0
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h0E, 3'b000, 4'd8},  // R8
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h0F, 3'b010, 4'd9},  // R9 irq back
    '{1'b1, 1'b0, 8'h58, 32'h00, 32'h00, 3'b010, 4'd8},  // R8 zeros ignored
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h0F, 3'b010, 4'd8},  // R8
    '{1'b1, 1'b0, 8'h58, 32'h01, 32'h00, 3'b010, 4'd8},  // R8 clear vs set
    '{1'b0, 1'b1, 8'h58, 32'h00, 32'h0F, 3'b010, 4'd8},  // R8 set wins
    '{1'b0, 1'b1, 8'h6C, 32'h00, 32'h00, 3'b010, 4'd1},  // R1 unmapped
    '{1'b0, 1'b1, 8'h02, 32'h00, 32'h00, 3'b010, 4'd1},  // R1 misaligned
    '{1'b0, 1'b1, 8'h14, 32'h00, 32'h01, 3'b010, 4'd1}   // R1 ch2 ctrl
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input int req, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s act=0x%0h exp=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i  = a;
    wdata_i = d;
    we_i    = 1'b1;
    @(negedge clk_i);
    we_i    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp,
                    input int req, input string what);
    addr_i = a;
    #1;
    check(rdata_o, exp, req, what);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni  = 1'b0;
    we_i    = 1'b0;
    addr_i  = '0;
    wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    check(32'(irq_o), 32'h0, 10, "irq after reset");

    for (int i = 0; i < 41; i++) begin
      @(negedge clk_i);
      addr_i  = VEC[i].addr;
      wdata_i = VEC[i].wdata;
      we_i    = VEC[i].we;
      #1;
      if (VEC[i].chk) check(rdata_o, VEC[i].exp, int'(VEC[i].req), "table read");
      check(32'(irq_o), 32'(VEC[i].irq), int'(VEC[i].req), "table irq");
    end

    // R5: full free-running wrap on ch2
    wr(8'h68, 32'h10);
    wr(8'h14, 32'h10);
    repeat (65535) @(negedge clk_i);
    rd(8'h20, 32'hFFFF, 5, "count before wrap");
    rd(8'h5C, 32'h0, 5, "status before wrap");
    check(32'(irq_o[2]), 32'h0, 5, "irq before wrap");
    @(negedge clk_i);
    rd(8'h20, 32'h0, 5, "count after wrap");
    rd(8'h5C, 32'h1E, 5, "status after wrap");
    check(32'(irq_o[2]), 32'h1, 5, "irq after wrap");

    // R9: clearing ch2 leaves ch1 asserted
    wr(8'h5C, 32'h1E);
    check(32'(irq_o), 32'b010, 9, "channel independence");

    // R2: 0x9 divides by 32
    wr(8'h08, 32'h09);
    wr(8'h14, 32'h10);
    repeat (31) @(negedge clk_i);
    rd(8'h20, 32'h0, 2, "div32 before tick");
    @(negedge clk_i);
    rd(8'h20, 32'h1, 2, "div32 first tick");

    // R4: restart while stopped
    wr(8'h14, 32'h11);
    repeat (5) @(negedge clk_i);
    rd(8'h20, 32'h0, 4, "restart stopped count");
    rd(8'h14, 32'h1, 4, "restart bit reads 0");

    // R10: asynchronous reset mid-run
    rst_ni = 1'b0;
    #1;
    rd(8'h18, 32'h0, 10, "count in reset");
    rd(8'h0C, 32'h1, 10, "ctrl in reset");
    rd(8'h58, 32'h0, 10, "status in reset");
    check(32'(irq_o), 32'h0, 10, "irq in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule